// File: doc/BRIEF.md
# Redundant Residual Sign and Zero Detector

This block examines the last partial remainder of a digit-recurrence divider. That remainder is held in carry-save form, as a sum word and a carry word of equal width. The block reports two things about the value the pair represents: whether it is negative and whether it is exactly zero. A rounding or quotient-correction stage uses these flags. The block never forms the full binary sum.

Inside, the pair is first merged with a constant all-ones word in a row of 3:2 compressors. This gives a second sum/carry pair whose total is one less than the residual. The residual is zero exactly when the second pair is bitwise complementary, so zero detection becomes an AND of per-bit XOR terms. The sign bit of the residual is the top-bit sum of the two input words XORed with the carry into the top bit. That carry comes from a two-level lookahead network: generate/propagate pairs over 4-bit groups, then a combine step across the groups.

The block samples its inputs on each rising clock edge. Both flags come from registers and appear one cycle after the inputs they describe. A synchronous active-high reset clears them. The width is a parameter and must be a multiple of the group size.

Top module: `csd_sign_zero`

## Requirements
- R1: While `rst` is high at a rising edge, both `sign` and `zero` are 0 after that edge, whatever `ws` and `wc` hold.
- R2: The flags are registered: they change only at a rising edge and then describe the `ws`/`wc` values sampled at that edge, one cycle of latency.
- R3: `sign` equals bit WIDTH-1 of (`ws` + `wc`) taken modulo 2^WIDTH, including when a carry ripples from bit 0 all the way to the top bit.
- R4: `zero` is 1 exactly when (`ws` + `wc`) modulo 2^WIDTH is 0, including when both words are nonzero (for example `ws` = 1 and `wc` all ones).
- R5: A carry out of bit WIDTH-1 is discarded: `ws` = `wc` = 2^(WIDTH-1) gives `zero` = 1 and `sign` = 0.
- R6: The most negative value (only bit WIDTH-1 of the sum set) gives `sign` = 1 and `zero` = 0, whether it is presented as one word or split across both.
- R7: The value -1 (sum all ones) gives `sign` = 1 and `zero` = 0.
- R8: `zero` and `sign` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ws | input | WIDTH | Sum word of the carry-save residual |
| wc | input | WIDTH | Carry word of the carry-save residual |
| sign | output | 1 | Registered: residual is negative |
| zero | output | 1 | Registered: residual is exactly zero |

## Verification
The hardest cases are those where the flag depends on a carry that crosses every lookahead group. Examples are a positive maximum plus one that turns negative, and a zero total built from two nonzero words. Uniform random words almost never produce these. The stimulus therefore builds them directly: it picks a random word and pairs it with its two's complement, places the total exactly at the negative extreme or at -1, and makes the words overflow past the top bit. Random pairs fill in between, and a model in the bench compares both flags on every clock.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int GRP_W = 4;

  typedef struct packed {
    logic g;
    logic p;
    logic z;
  } grp_sig_t;
endpackage

// File: rtl/csd_offset_csa.sv
module csd_offset_csa #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] ws,
  input  logic [WIDTH-1:0] wc,
  output logic [WIDTH-1:0] a_s,
  output logic [WIDTH-1:0] a_c
);
  logic [WIDTH-1:0] maj;

  // 3:2 compression with a constant all-ones third operand
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      a_s[i] = ~(ws[i] ^ wc[i]);
      maj[i] = ws[i] | wc[i];
    end
    a_c = {maj[WIDTH-2:0], 1'b0};
  end
endmodule

// File: rtl/csd_group.sv
module csd_group #(
  parameter int GW   = 4,
  parameter int SPAN = 4
) (
  input  logic [SPAN-1:0]     ws_s,
  input  logic [SPAN-1:0]     wc_s,
  input  logic [GW-1:0]       as_s,
  input  logic [GW-1:0]       ac_s,
  output csd_pkg::grp_sig_t   grp
);
  logic g_acc;
  logic p_acc;

  always_comb begin
    g_acc = 1'b0;
    p_acc = 1'b1;
    for (int i = 0; i < SPAN; i++) begin
      g_acc = (ws_s[i] & wc_s[i]) | ((ws_s[i] ^ wc_s[i]) & g_acc);
      p_acc = p_acc & (ws_s[i] ^ wc_s[i]);
    end
    grp.g = g_acc;
    grp.p = p_acc;
    grp.z = &(as_s ^ ac_s);
  end
endmodule

// File: rtl/csd_tree.sv
module csd_tree #(
  parameter int NG = 16
) (
  input  csd_pkg::grp_sig_t [NG-1:0] grp,
  output logic                       c_top,
  output logic                       all_zero
);
  logic cin_grp;

  always_comb begin
    cin_grp  = 1'b0;
    all_zero = 1'b1;
    for (int k = 0; k < NG; k++) begin
      all_zero = all_zero & grp[k].z;
      if (k < NG-1) cin_grp = grp[k].g | (grp[k].p & cin_grp);
    end
    // top group spans only the bits below the MSB
    c_top = grp[NG-1].g | (grp[NG-1].p & cin_grp);
  end
endmodule

// File: rtl/csd_sign_zero.sv
module csd_sign_zero #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] ws,
  input  logic [WIDTH-1:0] wc,
  output logic             sign,
  output logic             zero
);
  localparam int GW = csd_pkg::GRP_W;
  localparam int NG = WIDTH / GW;

  if ((WIDTH % GW) != 0 || WIDTH < GW) begin : g_bad_width
    $error("csd_sign_zero: WIDTH must be a positive multiple of the group size");
  end

  logic [WIDTH-1:0]            a_s;
  logic [WIDTH-1:0]            a_c;
  csd_pkg::grp_sig_t [NG-1:0]  grp;
  logic                        c_top;
  logic                        all_zero;
  logic                        sign_d;

  csd_offset_csa #(.WIDTH(WIDTH)) csa_i (
    .ws (ws),
    .wc (wc),
    .a_s(a_s),
    .a_c(a_c)
  );

  for (genvar k = 0; k < NG; k++) begin : g_grp
    if (k == NG-1) begin : g_top
      csd_group #(.GW(GW), .SPAN(GW-1)) grp_i (
        .ws_s(ws[k*GW +: GW-1]),
        .wc_s(wc[k*GW +: GW-1]),
        .as_s(a_s[k*GW +: GW]),
        .ac_s(a_c[k*GW +: GW]),
        .grp (grp[k])
      );
    end else begin : g_full
      csd_group #(.GW(GW), .SPAN(GW)) grp_i (
        .ws_s(ws[k*GW +: GW]),
        .wc_s(wc[k*GW +: GW]),
        .as_s(a_s[k*GW +: GW]),
        .ac_s(a_c[k*GW +: GW]),
        .grp (grp[k])
      );
    end
  end

  csd_tree #(.NG(NG)) tree_i (
    .grp     (grp),
    .c_top   (c_top),
    .all_zero(all_zero)
  );

  assign sign_d = ws[WIDTH-1] ^ wc[WIDTH-1] ^ c_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      sign <= 1'b0;
      zero <= 1'b0;
    end else begin
      sign <= sign_d;
      zero <= all_zero;
    end
  end
endmodule

// File: rtl/csd_sign_zero_chk.sv
module csd_sign_zero_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] ws,
  input logic [WIDTH-1:0] wc,
  input logic             sign,
  input logic             zero
);
  logic [WIDTH-1:0] ref_sum;
  logic [1:0]       phase = 2'd0;

  assign ref_sum = ws + wc;

  // phase 2: at least one edge out of reset has loaded real inputs
  always_ff @(posedge clk) begin
    if (rst) phase <= 2'd1;
    else if (phase != 2'd0) phase <= 2'd2;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    (phase != 2'd0 && $past(rst)) |-> (!sign && !zero)); // R1

  AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2 && !$past(rst)) |-> (sign == $past(ref_sum[WIDTH-1]))); // R3

  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2 && !$past(rst)) |-> (zero == ($past(ref_sum) == '0))); // R4

  AST_NO_BOTH_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2) |-> !(zero && sign)); // R8
endmodule

bind csd_sign_zero csd_sign_zero_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/csd_sign_zero_tb_top.sv
`timescale 1ns/1ps
module csd_sign_zero_tb_top;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] ws  = '0;
  logic [W-1:0] wc  = '0;
  logic         sign;
  logic         zero;

  int    n_cmp  = 0;
  int    n_bad  = 0;
  bit    done   = 1'b0;
  bit    have_exp = 1'b0;
  logic  exp_sign;
  logic  exp_zero;
  string exp_tag;

  always #2.5 clk = ~clk;

  csd_sign_zero #(.WIDTH(W)) dut_i (
    .clk (clk),
    .rst (rst),
    .ws  (ws),
    .wc  (wc),
    .sign(sign),
    .zero(zero)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // compare pending expectation, then drive a new residual pair
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    logic [W-1:0] s;
    @(negedge clk);
    if (have_exp) begin
      check(sign, exp_sign, exp_tag, "sign");
      check(zero, exp_zero, exp_tag, "zero");
      check(sign & zero, 1'b0, "R8", "both flags");
    end
    ws = a;
    wc = b;
    s  = a + b;
    exp_sign = s[W-1];
    exp_zero = (s == '0);
    exp_tag  = tag;
    have_exp = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] MSB  = {1'b1, {(W-1){1'b0}}};

  initial begin
    logic [W-1:0] x;
    // R1: reset with inputs that would otherwise set sign
    rst = 1'b1;
    ws  = ONES;
    wc  = '0;
    repeat (3) @(negedge clk);
    check(sign, 1'b0, "R1", "sign in reset");
    check(zero, 1'b0, "R1", "zero in reset");
    ws = '0;
    repeat (2) @(negedge clk);
    check(zero, 1'b0, "R1", "zero in reset, zero inputs");
    rst = 1'b0;

    step(64'd5, 64'd7, "R3");
    step(64'd1, ONES, "R4");            // zero from nonzero words
    // R2: outputs hold until the next edge after inputs change
    @(negedge clk);
    check(zero, 1'b1, "R2", "zero after edge");
    ws = 64'd3;
    wc = 64'd4;
    #1;
    check(zero, 1'b1, "R2", "zero holds before edge");
    check(sign, 1'b0, "R2", "sign holds before edge");
    have_exp = 1'b0;
    step(64'd3, 64'd4, "R2");
    step(MSB - 64'd1, 64'd1, "R3");     // carry ripples to the top bit
    step(64'h0FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, "R3");
    step(MSB, MSB, "R5");               // overflow discarded
    step(ONES, ONES - 64'd0 + 64'd1, "R5");
    step(MSB, 64'd0, "R6");
    step(MSB >> 1, MSB >> 1, "R6");     // split most negative
    step(ONES, 64'd0, "R7");
    step(64'd5, ~64'd5, "R7");          // 5 + (-6) = -1
    step(64'd0, 64'd0, "R4");
    for (int i = 0; i < 400; i++) begin
      x = {$urandom, $urandom};
      case (i % 4)
        0: step(x, -x, "R4");
        1: step(x, ONES - x, "R7");
        2: step(x, MSB - x, "R6");
        default: step(x, {$urandom, $urandom}, "R3");
      endcase
    end
    step(64'd0, 64'd0, "R4");           // flush last expectation
    @(negedge clk);
    check(sign, exp_sign, exp_tag, "sign");
    check(zero, exp_zero, exp_tag, "zero");
    finish_run();
  end

  initial begin
    #100000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule